// File: doc/BRIEF.md
# Video Memory DMA Engine

This block moves data into the three on-chip video memories: the byte-addressed video RAM (VRAM), the word-wide colour RAM (CRAM) and the word-wide vertical-scroll RAM (VSRAM). A job is configured by pulsing `cfg_start` while the engine is idle. That pulse latches the mode, the target memory, the destination address, the address step, the 24-bit source address, the word count and the fill value. Once started, the engine does at most one memory action per external access slot. A slot is a cycle with `access_slot` high while `dma_enable` is also high. The engine keeps doing this until the word count runs out.

The engine has three operating kinds:

- **Transfer:** fetches words from an external source bus through a request/valid handshake.
- **Fill:** writes a constant value.
- **Copy:** reads a value from the target memory itself and writes it back at the destination.

VRAM is byte-wide, so a word written to VRAM takes two slots. Copy always spends one slot reading and the following slot writing.

The controller has four states:

- **ST_IDLE:** no job is running.
- **ST_FIRST:** waiting for the first slot of a word.
- **ST_WAIT:** an external fetch is outstanding.
- **ST_SECOND:** the second half of a VRAM word or of a copy is pending.

The transitions are:

- ST_IDLE→ST_FIRST on a start pulse.
- ST_FIRST→ST_WAIT when a transfer fetch gets no valid in its slot.
- ST_FIRST→ST_SECOND after a first VRAM byte or a copy read.
- ST_WAIT→ST_SECOND on valid for a VRAM target.
- ST_FIRST, ST_WAIT or ST_SECOND→ST_FIRST when a word completes and more words remain.
- The same three states→ST_IDLE when the completed word was the last one.

Top module: `vram_dma_engine`

## Requirements
- R1: After reset `busy` is 0, `status` is 8'h00, and all of `mem_we`, `mem_re` and `ext_req` are 0.
- R2: A `cfg_start` pulse while idle makes `busy` 1 from the next cycle. A pulse while busy is ignored and does not alter the running job. `status` bit 5 equals `busy` and every other `status` bit is 0.
- R3: The memory and request strobes fire only in a cycle with `access_slot` and `dma_enable` both high. The one exception is an outstanding external fetch in ST_WAIT. With `dma_enable` low the job stays frozen.
- R4: The mode is decoded from `cfg_mode`: 00 or 01 is a transfer, 10 is a fill, 11 is a copy. The target is decoded from `cfg_target`: 01 is VRAM, 10 is CRAM, 11 is VSRAM, 00 is none. `mem_we` and `mem_re` are one-hot with bit 0 for VRAM, bit 1 for CRAM and bit 2 for VSRAM. A transfer to VRAM works as follows:
  - The first slot writes the fetched word's bits 15:8 at the address.
  - The next slot writes bits 7:0 at the address XOR 1.
  - VRAM byte data appears on `mem_wdata[7:0]` with bits 15:8 zero.
- R5: A fill to VRAM writes the fill value's low byte at the address in the first slot. It writes the high byte at the address XOR 1 in the next slot.
- R6: A copy works as follows:
  - It reads the target memory in one slot and writes that value to the same memory in the next slot.
  - For VRAM, the read address is source bits 15:0 and the byte `mem_rdata[7:0]` is written at the address.
  - For CRAM and VSRAM, the read index is formed from source bits 7:0.
- R7: After every completed word:
  - The address advances by `cfg_inc` (16-bit wrap).
  - Source bits 7:0 increment with an 8-bit wrap and no carry into bits 23:8.
  - The count decrements by one.
  - When the count reaches 0 the engine returns to idle. A start count of 0 means 65536 words.
- R8: The CRAM index is (address/2) modulo CRAM_DEPTH. The VSRAM index is (address/2) & 63, and a VSRAM write whose index is at least VSRAM_DEPTH is dropped. A VSRAM copy read at an out-of-range index issues no read and yields 0.
- R9: A transfer raises `ext_req` with `ext_addr` equal to the 24-bit source. The request is held until `ext_valid`, and the fetched data is written in the cycle `ext_valid` is seen, even outside a slot.
- R10: A transfer or fill to CRAM or VSRAM completes one word per slot with a single word write.
- R11: With target code 00 each slot completes a word with no memory access and no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_start | input | 1 | Start pulse, honoured only when idle |
| cfg_mode | input | 2 | Operating kind code |
| cfg_target | input | 2 | Target memory code |
| cfg_addr | input | 16 | Destination address |
| cfg_inc | input | 8 | Address step per word |
| cfg_src | input | 24 | Source address |
| cfg_len | input | 16 | Word count (0 = 65536) |
| cfg_fill | input | 16 | Fill value |
| dma_enable | input | 1 | Global DMA enable |
| access_slot | input | 1 | External access slot strobe |
| ext_req | output | 1 | External fetch request |
| ext_addr | output | 24 | External fetch address |
| ext_valid | input | 1 | External data valid |
| ext_data | input | 16 | External fetched word |
| mem_we | output | 3 | One-hot write strobe (VRAM, CRAM, VSRAM) |
| mem_waddr | output | 16 | Write byte address (VRAM) or word index |
| mem_wdata | output | 16 | Write data |
| mem_re | output | 3 | One-hot read strobe for copy |
| mem_raddr | output | 16 | Read byte address or word index |
| mem_rdata | input | 16 | Read data of the strobed memory, same cycle |
| busy | output | 1 | Job running |
| status | output | 8 | Status byte, bit 5 = busy |

## Verification
Every strobe, address, data value and request is combinational from the registered state and the current slot, valid and read-data inputs. The bench therefore expects each of them in the very cycle its slot or its valid arrives, and `busy` one edge after a start or after the last word. The bench drives inputs just after the rising edge and samples all outputs at the falling edge. At each falling edge it evaluates its own behavioural model against the same inputs and compares every output. The model commits its next state on the rising edge, so each expectation lines up exactly with the register that produces it.

// File: rtl/vdma_pkg.sv
package vdma_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_FIRST  = 2'd1,
        ST_WAIT   = 2'd2,
        ST_SECOND = 2'd3
    } vdma_state_e;

    typedef enum logic [1:0] {
        K_XFER = 2'd0,
        K_FILL = 2'd1,
        K_COPY = 2'd2
    } vdma_kind_e;

    localparam logic [1:0] TGT_NONE  = 2'b00;
    localparam logic [1:0] TGT_VRAM  = 2'b01;
    localparam logic [1:0] TGT_CRAM  = 2'b10;
    localparam logic [1:0] TGT_VSRAM = 2'b11;

    function automatic vdma_kind_e kind_of(input logic [1:0] code);
        if (!code[1])     return K_XFER;
        else if (!code[0]) return K_FILL;
        else              return K_COPY;
    endfunction

endpackage

// File: rtl/vdma_index.sv
module vdma_index #(
    parameter int IDX_W       = 16,
    parameter int CRAM_DEPTH  = 64,
    parameter int VSRAM_DEPTH = 40,
    parameter int VSRAM_SPAN  = 64
) (
    input  logic [IDX_W-1:0] word_sel,
    output logic [IDX_W-1:0] cram_idx,
    output logic [IDX_W-1:0] vsram_idx,
    output logic             vsram_ok
);
    localparam int CW = $clog2(CRAM_DEPTH);
    localparam int VW = $clog2(VSRAM_SPAN);

    assign cram_idx  = {{(IDX_W-CW){1'b0}}, word_sel[CW-1:0]};
    assign vsram_idx = {{(IDX_W-VW){1'b0}}, word_sel[VW-1:0]};
    assign vsram_ok  = vsram_idx < IDX_W'(VSRAM_DEPTH);
endmodule

// File: rtl/vdma_cursor.sv
module vdma_cursor #(
    parameter int ADDR_W = 16,
    parameter int SRC_W  = 24,
    parameter int LEN_W  = 16,
    parameter int INC_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] load_addr,
    input  logic [SRC_W-1:0]  load_src,
    input  logic [LEN_W-1:0]  load_len,
    input  logic [INC_W-1:0]  load_inc,
    input  logic              advance,
    output logic [ADDR_W-1:0] addr,
    output logic [SRC_W-1:0]  src,
    output logic              last
);
    localparam int LOW_W = 8;

    logic [LEN_W-1:0] len_q;
    logic [INC_W-1:0] inc_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr  <= '0;
            src   <= '0;
            len_q <= '0;
            inc_q <= '0;
        end else if (load) begin
            addr  <= load_addr;
            src   <= load_src;
            len_q <= load_len;
            inc_q <= load_inc;
        end else if (advance) begin
            addr  <= addr + ADDR_W'(inc_q);
            src   <= {src[SRC_W-1:LOW_W], src[LOW_W-1:0] + LOW_W'(1)};
            len_q <= len_q - LEN_W'(1);
        end
    end

    assign last = (len_q == LEN_W'(1));

    // R7: low source byte steps by one and never carries upward
    a_r7_src_low_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        advance && !load |=> (src[LOW_W-1:0] == $past(src[LOW_W-1:0]) + LOW_W'(1))
                             && (src[SRC_W-1:LOW_W] == $past(src[SRC_W-1:LOW_W])));

    // R7: address advances by the latched step per completed word
    a_r7_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
        advance && !load |=> addr == $past(addr) + ADDR_W'($past(inc_q)));
endmodule

// File: rtl/vram_dma_engine.sv
module vram_dma_engine
    import vdma_pkg::*;
#(
    parameter int ADDR_W      = 16,
    parameter int SRC_W       = 24,
    parameter int LEN_W       = 16,
    parameter int INC_W       = 8,
    parameter int DATA_W      = 16,
    parameter int CRAM_DEPTH  = 64,
    parameter int VSRAM_DEPTH = 40
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_start,
    input  logic [1:0]        cfg_mode,
    input  logic [1:0]        cfg_target,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [INC_W-1:0]  cfg_inc,
    input  logic [SRC_W-1:0]  cfg_src,
    input  logic [LEN_W-1:0]  cfg_len,
    input  logic [DATA_W-1:0] cfg_fill,
    input  logic              dma_enable,
    input  logic              access_slot,
    output logic              ext_req,
    output logic [SRC_W-1:0]  ext_addr,
    input  logic              ext_valid,
    input  logic [DATA_W-1:0] ext_data,
    output logic [2:0]        mem_we,
    output logic [ADDR_W-1:0] mem_waddr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic [2:0]        mem_re,
    output logic [ADDR_W-1:0] mem_raddr,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              busy,
    output logic [7:0]        status
);
    localparam int HALF_W   = DATA_W / 2;
    localparam int BUSY_BIT = 5;

    vdma_state_e       state, state_d;
    vdma_kind_e        kind_q;
    logic [1:0]        tgt_q;
    logic [DATA_W-1:0] fill_q, val_q, cap_val;
    logic              capture, advance, last, load, step;
    logic [ADDR_W-1:0] addr;
    logic [SRC_W-1:0]  src;
    logic [ADDR_W-1:0] d_cidx, d_vidx, s_cidx, s_vidx;
    logic              d_vok, s_vok;

    assign load = (state == ST_IDLE) && cfg_start;
    assign step = access_slot && dma_enable;

    vdma_cursor #(.ADDR_W(ADDR_W), .SRC_W(SRC_W), .LEN_W(LEN_W), .INC_W(INC_W)) cursor_i (
        .clk(clk), .rst_n(rst_n), .load(load),
        .load_addr(cfg_addr), .load_src(cfg_src), .load_len(cfg_len), .load_inc(cfg_inc),
        .advance(advance), .addr(addr), .src(src), .last(last)
    );

    // destination index from address/2, copy-source index from the low source byte
    vdma_index #(.IDX_W(ADDR_W), .CRAM_DEPTH(CRAM_DEPTH), .VSRAM_DEPTH(VSRAM_DEPTH)) dst_idx_i (
        .word_sel({1'b0, addr[ADDR_W-1:1]}), .cram_idx(d_cidx), .vsram_idx(d_vidx), .vsram_ok(d_vok)
    );
    vdma_index #(.IDX_W(ADDR_W), .CRAM_DEPTH(CRAM_DEPTH), .VSRAM_DEPTH(VSRAM_DEPTH)) src_idx_i (
        .word_sel({{(ADDR_W-8){1'b0}}, src[7:0]}), .cram_idx(s_cidx), .vsram_idx(s_vidx), .vsram_ok(s_vok)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_d;
    end

    // job configuration and held word
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            kind_q <= K_XFER;
            tgt_q  <= TGT_NONE;
            fill_q <= '0;
            val_q  <= '0;
        end else begin
            if (load) begin
                kind_q <= kind_of(cfg_mode);
                tgt_q  <= cfg_target;
                fill_q <= cfg_fill;
            end
            if (capture) val_q <= cap_val;
        end
    end

    // next state and outputs
    always_comb begin
        state_d   = state;
        mem_we    = '0;
        mem_waddr = '0;
        mem_wdata = '0;
        mem_re    = '0;
        mem_raddr = '0;
        ext_req   = 1'b0;
        ext_addr  = '0;
        advance   = 1'b0;
        capture   = 1'b0;
        cap_val   = '0;
        unique case (state)
            ST_IDLE: begin
                if (cfg_start) state_d = ST_FIRST;
            end
            ST_FIRST, ST_WAIT: begin
                if (state == ST_WAIT || (step && kind_q == K_XFER && tgt_q != TGT_NONE)) begin
                    ext_req  = 1'b1;
                    ext_addr = src;
                    if (ext_valid) begin
                        case (tgt_q)
                            TGT_VRAM: begin
                                mem_we[0] = 1'b1;
                                mem_waddr = addr;
                                mem_wdata = {{HALF_W{1'b0}}, ext_data[DATA_W-1:HALF_W]};
                                capture   = 1'b1;
                                cap_val   = ext_data;
                                state_d   = ST_SECOND;
                            end
                            TGT_CRAM: begin
                                mem_we[1] = 1'b1;
                                mem_waddr = d_cidx;
                                mem_wdata = ext_data;
                                advance   = 1'b1;
                            end
                            default: begin
                                mem_we[2] = d_vok;
                                mem_waddr = d_vidx;
                                mem_wdata = ext_data;
                                advance   = 1'b1;
                            end
                        endcase
                    end else begin
                        state_d = ST_WAIT;
                    end
                end else if (step) begin
                    if (tgt_q == TGT_NONE) begin
                        advance = 1'b1;
                    end else if (kind_q == K_FILL) begin
                        case (tgt_q)
                            TGT_VRAM: begin
                                mem_we[0] = 1'b1;
                                mem_waddr = addr;
                                mem_wdata = {{HALF_W{1'b0}}, fill_q[HALF_W-1:0]};
                                state_d   = ST_SECOND;
                            end
                            TGT_CRAM: begin
                                mem_we[1] = 1'b1;
                                mem_waddr = d_cidx;
                                mem_wdata = fill_q;
                                advance   = 1'b1;
                            end
                            default: begin
                                mem_we[2] = d_vok;
                                mem_waddr = d_vidx;
                                mem_wdata = fill_q;
                                advance   = 1'b1;
                            end
                        endcase
                    end else begin
                        capture = 1'b1;
                        state_d = ST_SECOND;
                        case (tgt_q)
                            TGT_VRAM: begin
                                mem_re[0] = 1'b1;
                                mem_raddr = src[ADDR_W-1:0];
                                cap_val   = {{HALF_W{1'b0}}, mem_rdata[HALF_W-1:0]};
                            end
                            TGT_CRAM: begin
                                mem_re[1] = 1'b1;
                                mem_raddr = s_cidx;
                                cap_val   = mem_rdata;
                            end
                            default: begin
                                mem_re[2] = s_vok;
                                mem_raddr = s_vidx;
                                cap_val   = s_vok ? mem_rdata : '0;
                            end
                        endcase
                    end
                end
            end
            ST_SECOND: begin
                if (step) begin
                    advance = 1'b1;
                    if (kind_q == K_XFER) begin
                        mem_we[0] = 1'b1;
                        mem_waddr = addr ^ ADDR_W'(1);
                        mem_wdata = {{HALF_W{1'b0}}, val_q[HALF_W-1:0]};
                    end else if (kind_q == K_FILL) begin
                        mem_we[0] = 1'b1;
                        mem_waddr = addr ^ ADDR_W'(1);
                        mem_wdata = {{HALF_W{1'b0}}, fill_q[DATA_W-1:HALF_W]};
                    end else begin
                        case (tgt_q)
                            TGT_VRAM: begin
                                mem_we[0] = 1'b1;
                                mem_waddr = addr;
                                mem_wdata = {{HALF_W{1'b0}}, val_q[HALF_W-1:0]};
                            end
                            TGT_CRAM: begin
                                mem_we[1] = 1'b1;
                                mem_waddr = d_cidx;
                                mem_wdata = val_q;
                            end
                            default: begin
                                mem_we[2] = d_vok;
                                mem_waddr = d_vidx;
                                mem_wdata = val_q;
                            end
                        endcase
                    end
                end
            end
            default: state_d = ST_IDLE;
        endcase
        if (advance) state_d = last ? ST_IDLE : ST_FIRST;
    end

    assign busy   = (state != ST_IDLE);
    assign status = 8'(busy) << BUSY_BIT;

    // R3: no strobe outside a slot unless a fetch is outstanding
    a_r3_quiet_outside_slot: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_WAIT && !step) |-> (mem_we == 3'b000 && mem_re == 3'b000 && !ext_req));

    // R9: an unanswered request stays up on the next cycle
    a_r9_req_held: assert property (@(posedge clk) disable iff (!rst_n)
        ext_req && !ext_valid |=> ext_req);

    // R8: a VSRAM write never lands at or beyond the VSRAM depth
    a_r8_vsram_bound: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we[2] |-> mem_waddr < ADDR_W'(VSRAM_DEPTH));

    // R4: at most one memory strobe in any cycle
    a_r4_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({mem_we, mem_re}));

    // R7: the final word returns the engine to idle
    a_r7_last_word_idle: assert property (@(posedge clk) disable iff (!rst_n)
        advance && last |=> !busy);
endmodule

// File: tb/vram_dma_engine_tb.sv
module vram_dma_engine_tb_top;
    localparam int CRAM_N = 64;
    localparam int VS_N   = 40;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_start = 1'b0;
    logic [1:0]  cfg_mode = 2'b00, cfg_target = 2'b00;
    logic [15:0] cfg_addr = '0, cfg_len = '0, cfg_fill = '0;
    logic [7:0]  cfg_inc = '0;
    logic [23:0] cfg_src = '0;
    logic        dma_enable = 1'b1, access_slot = 1'b0;
    logic        ext_req, ext_valid;
    logic [23:0] ext_addr;
    logic [15:0] ext_data;
    logic [2:0]  mem_we, mem_re;
    logic [15:0] mem_waddr, mem_wdata, mem_raddr, mem_rdata;
    logic        busy;
    logic [7:0]  status;

    int vectors = 0, miscompares = 0, cyc = 0, slot_div = 1, rsp_lat = 0, rsp_cnt = 0;
    string cur_tag = "R1";

    always #4 clk = ~clk;

    function automatic logic [15:0] ext_fn(input logic [23:0] a);
        return a[15:0] ^ 16'hC3A5 ^ {a[23:16], 8'h00};
    endfunction
    function automatic logic [15:0] rd_fn(input logic [2:0] which, input logic [15:0] a);
        logic [15:0] p;
        p = a * 16'h0137;
        return p ^ {which, 13'h0155};
    endfunction

    assign ext_valid = ext_req && (rsp_cnt >= rsp_lat);
    assign ext_data  = ext_fn(ext_addr);
    assign mem_rdata = (mem_re != 3'b000) ? rd_fn(mem_re, mem_raddr) : 16'h0000;

    vram_dma_engine dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_start(cfg_start), .cfg_mode(cfg_mode),
        .cfg_target(cfg_target), .cfg_addr(cfg_addr), .cfg_inc(cfg_inc), .cfg_src(cfg_src),
        .cfg_len(cfg_len), .cfg_fill(cfg_fill), .dma_enable(dma_enable), .access_slot(access_slot),
        .ext_req(ext_req), .ext_addr(ext_addr), .ext_valid(ext_valid), .ext_data(ext_data),
        .mem_we(mem_we), .mem_waddr(mem_waddr), .mem_wdata(mem_wdata), .mem_re(mem_re),
        .mem_raddr(mem_raddr), .mem_rdata(mem_rdata), .busy(busy), .status(status)
    );

    // ---------------- behavioural reference model ----------------
    logic        m_busy = 1'b0, n_busy;
    int          m_ph = 0, n_ph;            // 0 first, 1 waiting on bus, 2 second half
    logic [1:0]  m_mode, m_tgt, n_mode, n_tgt;
    logic [15:0] m_addr, m_len, m_fill, m_val, n_addr, n_len, n_fill, n_val;
    logic [7:0]  m_inc, n_inc;
    logic [23:0] m_src, n_src;
    logic [2:0]  e_we, e_re;
    logic [15:0] e_waddr, e_wdata, e_raddr;
    logic        e_req;
    logic [23:0] e_eaddr;
    logic        req_s, valid_s;

    task automatic put(input logic [2:0] which, input logic [15:0] a, input logic [15:0] d);
        e_we = which; e_waddr = a; e_wdata = d;
    endtask

    task automatic put_word(input logic [15:0] d);
        int idx;
        if (m_tgt == 2'b10) put(3'b010, 16'((m_addr >> 1) & (CRAM_N - 1)), d);
        else if (m_tgt == 2'b11) begin
            idx = (m_addr >> 1) & 63;
            if (idx < VS_N) put(3'b100, 16'(idx), d);
        end
    endtask

    task automatic word_done();
        n_addr = m_addr + 16'(m_inc);
        n_src  = {m_src[23:8], m_src[7:0] + 8'd1};
        n_len  = m_len - 16'd1;
        if (n_len == 16'd0) n_busy = 1'b0;
        else n_ph = 0;
    endtask

    task automatic model_eval();
        logic go, fetch;
        logic [15:0] d;
        int idx;
        n_busy = m_busy; n_ph = m_ph; n_mode = m_mode; n_tgt = m_tgt; n_addr = m_addr;
        n_len = m_len; n_fill = m_fill; n_val = m_val; n_inc = m_inc; n_src = m_src;
        e_we = 0; e_re = 0; e_waddr = 0; e_wdata = 0; e_raddr = 0; e_req = 0; e_eaddr = 0;
        go = access_slot && dma_enable;
        if (!m_busy) begin
            if (cfg_start) begin
                n_busy = 1'b1; n_ph = 0; n_mode = cfg_mode; n_tgt = cfg_target;
                n_addr = cfg_addr; n_len = cfg_len; n_fill = cfg_fill; n_inc = cfg_inc; n_src = cfg_src;
            end
        end else begin
            fetch = (m_ph == 1) || (m_ph == 0 && go && !m_mode[1] && m_tgt != 2'b00);
            if (fetch) begin
                e_req = 1'b1; e_eaddr = m_src;
                if (rsp_cnt >= rsp_lat) begin
                    d = ext_fn(m_src);
                    if (m_tgt == 2'b01) begin
                        put(3'b001, m_addr, {8'h00, d[15:8]}); n_val = d; n_ph = 2;
                    end else begin
                        put_word(d); word_done();
                    end
                end else n_ph = 1;
            end else if (m_ph == 0 && go) begin
                if (m_tgt == 2'b00) word_done();
                else if (m_mode == 2'b10) begin
                    if (m_tgt == 2'b01) begin
                        put(3'b001, m_addr, {8'h00, m_fill[7:0]}); n_ph = 2;
                    end else begin
                        put_word(m_fill); word_done();
                    end
                end else begin
                    n_ph = 2;
                    if (m_tgt == 2'b01) begin
                        e_re = 3'b001; e_raddr = m_src[15:0];
                        n_val = rd_fn(3'b001, m_src[15:0]) & 16'h00FF;
                    end else if (m_tgt == 2'b10) begin
                        idx = m_src[7:0] & (CRAM_N - 1);
                        e_re = 3'b010; e_raddr = 16'(idx); n_val = rd_fn(3'b010, 16'(idx));
                    end else begin
                        idx = m_src[7:0] & 63;
                        if (idx < VS_N) begin
                            e_re = 3'b100; e_raddr = 16'(idx); n_val = rd_fn(3'b100, 16'(idx));
                        end else n_val = 16'h0000;
                    end
                end
            end else if (m_ph == 2 && go) begin
                if (m_mode == 2'b10)
                    put(3'b001, m_addr ^ 16'd1, {8'h00, m_fill[15:8]});
                else if (!m_mode[1])
                    put(3'b001, m_addr ^ 16'd1, {8'h00, m_val[7:0]});
                else if (m_tgt == 2'b01)
                    put(3'b001, m_addr, {8'h00, m_val[7:0]});
                else
                    put_word(m_val);
                word_done();
            end
        end
    endtask

    always @(negedge clk) begin
        req_s = ext_req; valid_s = ext_valid;
        if (rst_n) begin
            model_eval();
            vectors++;
            if (busy !== m_busy || status !== (m_busy ? 8'h20 : 8'h00) ||
                mem_we !== e_we || mem_re !== e_re || ext_req !== e_req ||
                (e_we != 0 && (mem_waddr !== e_waddr || mem_wdata !== e_wdata)) ||
                (e_re != 0 && mem_raddr !== e_raddr) ||
                (e_req && ext_addr !== e_eaddr)) begin
                miscompares++;
                $display("FAIL %s cyc %0d: actual busy=%b st=%h we=%b wa=%h wd=%h re=%b ra=%h req=%b ea=%h ; expected busy=%b we=%b wa=%h wd=%h re=%b ra=%h req=%b ea=%h",
                    cur_tag, cyc, busy, status, mem_we, mem_waddr, mem_wdata, mem_re, mem_raddr, ext_req, ext_addr,
                    m_busy, e_we, e_waddr, e_wdata, e_re, e_raddr, e_req, e_eaddr);
            end
        end
    end

    always @(posedge clk) begin
        if (!rst_n) begin
            m_busy <= 1'b0; m_ph <= 0; rsp_cnt <= 0;
        end else begin
            m_busy <= n_busy; m_ph <= n_ph; m_mode <= n_mode; m_tgt <= n_tgt; m_addr <= n_addr;
            m_len <= n_len; m_fill <= n_fill; m_val <= n_val; m_inc <= n_inc; m_src <= n_src;
            rsp_cnt <= (req_s && !valid_s) ? rsp_cnt + 1 : 0;
        end
    end

    // slot pattern
    always @(posedge clk) begin
        #1;
        cyc++;
        access_slot = ((cyc % slot_div) == 0);
    end

    // ---------------- stimulus helpers ----------------
    task automatic check(input bit ok, input string tag, input int act, input int exp);
        vectors++;
        if (!ok) begin
            miscompares++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic launch(input string tag, input logic [1:0] mode, input logic [1:0] tgt,
                          input logic [15:0] addr, input logic [7:0] inc, input logic [23:0] src,
                          input logic [15:0] len, input logic [15:0] fill);
        cur_tag = tag;
        @(posedge clk); #2;
        cfg_mode = mode; cfg_target = tgt; cfg_addr = addr; cfg_inc = inc;
        cfg_src = src; cfg_len = len; cfg_fill = fill; cfg_start = 1'b1;
        @(posedge clk); #2;
        cfg_start = 1'b0;
    endtask

    task automatic finish_job(input string tag);
        for (int k = 0; k < 3000 && m_busy; k++) @(posedge clk);
        @(negedge clk);
        check(busy == 1'b0, tag, busy, 0);
    endtask

    task automatic job(input string tag, input logic [1:0] mode, input logic [1:0] tgt,
                       input logic [15:0] addr, input logic [7:0] inc, input logic [23:0] src,
                       input logic [15:0] len, input logic [15:0] fill);
        launch(tag, mode, tgt, addr, inc, src, len, fill);
        finish_job(tag);
    endtask

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(busy == 1'b0, "R1 busy", busy, 0);
        check(status == 8'h00, "R1 status", status, 0);
        check(mem_we == 3'b000 && mem_re == 3'b000 && !ext_req, "R1 strobes", {mem_we, mem_re, ext_req}, 0);

        // R4 R9 R7: transfer into VRAM, fetch latency 2, low source byte wraps
        rsp_lat = 2; slot_div = 1;
        job("R4_R9_R7 xfer vram", 2'b00, 2'b01, 16'h1235, 8'd2, 24'h1234FE, 16'd3, 16'h0);
        // R9: immediate valid, sparse slots, mode 01 also a transfer
        rsp_lat = 0; slot_div = 3;
        job("R9 xfer vram mode01", 2'b01, 2'b01, 16'h2000, 8'd4, 24'h00FF10, 16'd2, 16'h0);
        // R5 fill VRAM
        job("R5 fill vram", 2'b10, 2'b01, 16'h0100, 8'd1, 24'h0, 16'd4, 16'hBEEF);
        // R6 copy VRAM
        slot_div = 2;
        job("R6 copy vram", 2'b11, 2'b01, 16'h4001, 8'd1, 24'h002000, 16'd3, 16'h0);
        // R10 R8 CRAM transfer wrapping its index
        rsp_lat = 1;
        job("R10_R8 xfer cram", 2'b00, 2'b10, 16'h007C, 8'd2, 24'h05A0F0, 16'd3, 16'h0);
        // R8 VSRAM fill reaching beyond its depth
        slot_div = 1;
        job("R8 fill vsram drop", 2'b10, 2'b11, 16'h004C, 8'd2, 24'h0, 16'd4, 16'h1234);
        // R8 VSRAM copy from out-of-range index yields 0
        job("R8 copy vsram", 2'b11, 2'b11, 16'h0000, 8'd2, 24'h000026, 16'd3, 16'h0);
        // R6 CRAM copy
        job("R6 copy cram", 2'b11, 2'b10, 16'h0010, 8'd2, 24'h00003E, 16'd3, 16'h0);
        // R11 no-target code
        job("R11 no target", 2'b10, 2'b00, 16'h0000, 8'd1, 24'h0, 16'd3, 16'h5555);

        // R3 enable low freezes the job
        launch("R3 enable gate", 2'b10, 2'b01, 16'h0300, 8'd2, 24'h0, 16'd2, 16'hA55A);
        dma_enable = 1'b0;
        repeat (8) @(posedge clk);
        @(negedge clk);
        check(busy == 1'b1, "R3 frozen busy", busy, 1);
        check(mem_we == 3'b000, "R3 frozen no write", mem_we, 0);
        @(posedge clk); #2 dma_enable = 1'b1;
        finish_job("R3 enable gate");

        // R2 start while busy is ignored
        slot_div = 4;
        launch("R2 restart ignored", 2'b10, 2'b10, 16'h0020, 8'd2, 24'h0, 16'd3, 16'h7777);
        check(status == 8'h20, "R2 status bit5", status, 8'h20);
        @(posedge clk); #2;
        cfg_mode = 2'b00; cfg_target = 2'b01; cfg_addr = 16'hFFFF; cfg_len = 16'd9; cfg_start = 1'b1;
        @(posedge clk); #2 cfg_start = 1'b0;
        finish_job("R2 restart ignored");

        repeat (4) @(posedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule